// File: doc/BRIEF.md
# Priority Interlock Dead-Time Generator

This block conditions the two pulse-width commands for one half-bridge leg before they are sent to the isolated gate drivers. Each raw command first passes through a width-discriminating filter. The filter throws away short noise pulses and delays clean pulses by a fixed latency without changing their width. The filtered commands then pass through an interlock that gives channel A precedence. A final stage keeps the two outputs apart by a fixed dead time.

The interlock is deliberately asymmetric. A rising A command removes B at once, and A follows only once the bridge has been dark for the dead time. A B command is disregarded for as long as the filtered A command is high. Tying the B input high therefore turns a single A waveform into a complementary pair with the dead time inserted. Two stop inputs force outputs low in the same cycle: one acts on both channels and one acts per channel. Releasing either stop restarts the dead-time wait.

With the default parameters (100 MHz clock, dead time 40 cycles, reject limit 10 cycles, accept limit 35 cycles) the filter threshold is 22 cycles. All inputs are taken as already synchronous to `clk`.

Top module: `prio_deadtime_gen`

## Requirements
- R1: An input pulse that is sampled high (or low) on fewer than THRESH = (REJECT_CYC+ACCEPT_CYC)/2 consecutive clock edges (22 by default) has no effect on the outputs.
- R2: An isolated input pulse of W >= THRESH cycles on an idle bridge gives an output pulse of exactly W cycles on the same channel. The output rises THRESH+1 clock edges after the first edge that samples the input high.
- R3: While rstN is low, and directly after its release, both outputs are low.
- R4: When gateBCmd is high and inA is raised, gateBCmd falls THRESH+1 edges after the first edge that samples inA high. gateACmd then rises exactly DEAD_CYC cycles after gateBCmd fell.
- R5: While the filtered A command is high, inB has no effect: gateBCmd stays low and gateACmd stays high.
- R6: With inB held high, gateACmd falling is followed by gateBCmd rising exactly DEAD_CYC cycles later.
- R7: gateACmd and gateBCmd are never high in the same cycle.
- R8: An output can rise only after both outputs have been low for at least DEAD_CYC cycles. This holds even when the inputs themselves leave a shorter gap.
- R9: stopBoth high forces both outputs low in the same cycle.
- R10: stopCh[0] forces gateACmd low and stopCh[1] forces gateBCmd low, each in the same cycle. The other channel is not affected.
- R11: After the last stop input is released with a command still high, the matching output rises DEAD_CYC cycles after the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inA | input | 1 | Raw channel A command (high side) |
| inB | input | 1 | Raw channel B command (low side) |
| stopBoth | input | 1 | Forces both outputs low |
| stopCh | input | 2 | Per-channel stop, bit 0 for A, bit 1 for B |
| gateACmd | output | 1 | Conditioned channel A gate command |
| gateBCmd | output | 1 | Conditioned channel B gate command |

## Verification
The hardest situation to reach from the ports is a handover in which the inputs themselves leave less than the dead time between the channels. Only then does the block have to stretch the gap rather than simply pass it through. The stimulus drops inA and raises inB only a few cycles later. It also raises inA while B is already driven, and it releases a stop while a command is still held. The expected gap is then measured between the observed output edges. A long run of random hold lengths on all inputs is compared cycle by cycle against a reference model. This run exercises filter restarts that overlap the interlock.

// File: rtl/pidt_pkg.sv
package pidt_pkg;

  // Per-cycle decisions from the control to the datapath.
  typedef struct packed {
    logic clrGap;  // restart the dark-time counter
    logic nextA;   // registered A drive for the next cycle
    logic nextB;   // registered B drive for the next cycle
  } pidt_strobe_t;

  // Filter threshold chosen midway between the reject and accept limits.
  function automatic int filtThresh(input int rejCyc, input int accCyc);
    return (rejCyc + accCyc) / 2;
  endfunction

endpackage

// File: rtl/pidt_glitch_filter.sv
module pidt_glitch_filter #(
  parameter int THRESH = 22
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic level
);
  localparam int CW = $clog2(THRESH + 1);
  localparam logic [CW-1:0] RUN_LAST = CW'(THRESH - 1);

  logic [CW-1:0] runCnt;

  // Level follows the input only after THRESH consecutive differing samples;
  // both edges see the same latency, so pulse width is preserved.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level  <= 1'b0;
      runCnt <= '0;
    end else if (rawIn == level) begin
      runCnt <= '0;
    end else if (runCnt == RUN_LAST) begin
      level  <= rawIn;
      runCnt <= '0;
    end else begin
      runCnt <= runCnt + CW'(1);
    end
  end
endmodule

// File: rtl/pidt_datapath.sv
module pidt_datapath
  import pidt_pkg::*;
#(
  parameter int DEAD_CYC = 40,
  parameter int THRESH   = 22
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   rawIn,
  input  pidt_strobe_t stb,
  output logic [1:0]   filt,
  output logic [1:0]   drv,
  output logic         gapDone
);
  localparam int GW = $clog2(DEAD_CYC);
  localparam logic [GW-1:0] GAP_TOP = GW'(DEAD_CYC - 1);

  logic [GW-1:0] gapCnt;

  for (genvar ch = 0; ch < 2; ch++) begin : g_filt
    pidt_glitch_filter #(.THRESH(THRESH)) u_flt (
      .clk   (clk),
      .rstN  (rstN),
      .rawIn (rawIn[ch]),
      .level (filt[ch])
    );
  end

  // Counts cycles with the bridge dark and no stop, saturating one short
  // of the dead time so the turn-on edge lands exactly on DEAD_CYC.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (stb.clrGap) begin
      gapCnt <= '0;
    end else if (gapCnt != GAP_TOP) begin
      gapCnt <= gapCnt + GW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drv <= 2'b00;
    end else begin
      drv <= {stb.nextB, stb.nextA};
    end
  end

  assign gapDone = (drv == 2'b00) && (gapCnt == GAP_TOP);
endmodule

// File: rtl/pidt_control.sv
module pidt_control
  import pidt_pkg::*;
(
  input  logic [1:0]   filt,
  input  logic [1:0]   drv,
  input  logic         gapDone,
  input  logic         stopBoth,
  input  logic [1:0]   stopCh,
  output pidt_strobe_t stb,
  output logic [1:0]   holdOff
);
  logic reqA;
  logic reqB;

  always_comb begin
    holdOff = {stopBoth | stopCh[1], stopBoth | stopCh[0]};
    // A wins outright; B is only considered while filtered A is low.
    reqA = filt[0] & ~holdOff[0];
    reqB = filt[1] & ~filt[0] & ~holdOff[1];
    stb.nextA  = reqA & (drv[0] | gapDone);
    stb.nextB  = reqB & (drv[1] | gapDone);
    stb.clrGap = drv[0] | drv[1] | (|holdOff);
  end
endmodule

// File: rtl/prio_deadtime_gen.sv
module prio_deadtime_gen
  import pidt_pkg::*;
#(
  parameter int DEAD_CYC   = 40,
  parameter int REJECT_CYC = 10,
  parameter int ACCEPT_CYC = 35
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inA,
  input  logic       inB,
  input  logic       stopBoth,
  input  logic [1:0] stopCh,
  output logic       gateACmd,
  output logic       gateBCmd
);
  localparam int THRESH = filtThresh(REJECT_CYC, ACCEPT_CYC);

  pidt_strobe_t stb;
  logic [1:0]   filt;
  logic [1:0]   drv;
  logic [1:0]   holdOff;
  logic         gapDone;

  pidt_datapath #(.DEAD_CYC(DEAD_CYC), .THRESH(THRESH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .rawIn   ({inB, inA}),
    .stb     (stb),
    .filt    (filt),
    .drv     (drv),
    .gapDone (gapDone)
  );

  pidt_control u_ctl (
    .filt     (filt),
    .drv      (drv),
    .gapDone  (gapDone),
    .stopBoth (stopBoth),
    .stopCh   (stopCh),
    .stb      (stb),
    .holdOff  (holdOff)
  );

  assign gateACmd = drv[0] & ~holdOff[0];
  assign gateBCmd = drv[1] & ~holdOff[1];
endmodule

// File: rtl/prio_deadtime_gen_chk.sv
module prio_deadtime_gen_chk #(
  parameter int DEAD_CYC = 40
) (
  input logic       clk,
  input logic       rstN,
  input logic       stopBoth,
  input logic [1:0] stopCh,
  input logic       gateACmd,
  input logic       gateBCmd
);
  localparam int OW = $clog2(DEAD_CYC + 1);
  localparam logic [OW-1:0] OFF_TOP = OW'(DEAD_CYC);

  logic [OW-1:0] darkCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) darkCnt <= '0;
    else if (gateACmd || gateBCmd) darkCnt <= '0;
    else if (darkCnt != OFF_TOP) darkCnt <= darkCnt + OW'(1);
  end

  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(gateACmd && gateBCmd));

  assert_stop_both_R9: assert property (@(posedge clk) disable iff (!rstN)
    stopBoth |-> (!gateACmd && !gateBCmd));

  assert_stop_a_R10: assert property (@(posedge clk) disable iff (!rstN)
    stopCh[0] |-> !gateACmd);

  assert_stop_b_R10: assert property (@(posedge clk) disable iff (!rstN)
    stopCh[1] |-> !gateBCmd);

  assert_gap_a_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateACmd) |-> (darkCnt >= OFF_TOP));

  assert_gap_b_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateBCmd) |-> (darkCnt >= OFF_TOP));
endmodule

bind prio_deadtime_gen prio_deadtime_gen_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .stopBoth (stopBoth),
  .stopCh   (stopCh),
  .gateACmd (gateACmd),
  .gateBCmd (gateBCmd)
);

// File: tb/sim_prio_deadtime_gen.sv
`timescale 1ns/1ps
module sim_prio_deadtime_gen;
  localparam int DT  = 40;
  localparam int THR = 22;   // (10 + 35) / 2

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inA = 1'b0, inB = 1'b0, stopBoth = 1'b0;
  logic [1:0] stopCh = 2'b00;
  logic gateACmd, gateBCmd;

  prio_deadtime_gen u0 (
    .clk(clk), .rstN(rstN), .inA(inA), .inB(inB),
    .stopBoth(stopBoth), .stopCh(stopCh),
    .gateACmd(gateACmd), .gateBCmd(gateBCmd)
  );

  always #2 clk = ~clk;

  int nChk = 0, nFail = 0, cyc = 0;
  int hiA = 0, hiB = 0;
  int riseA = 0, fallA = 0, riseB = 0, fallB = 0;
  logic prevA = 1'b0, prevB = 1'b0;
  bit done = 1'b0;
  string curTag = "R3";

  // Reference model state, built from the requirements.
  logic [1:0] mLvl = 2'b00, mDrv = 2'b00;
  int mRun [2] = '{0, 0};
  int mGap = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    logic sA, sB, sAny, wantA, wantB, quiet;
    logic [1:0] raw;
    cyc++;
    if (!rstN) begin
      mLvl = 2'b00; mDrv = 2'b00; mRun[0] = 0; mRun[1] = 0; mGap = 0;
    end else begin
      sA = stopBoth | stopCh[0];
      sB = stopBoth | stopCh[1];
      sAny = stopBoth | stopCh[0] | stopCh[1];
      wantA = mLvl[0] && !sA;
      wantB = mLvl[1] && !mLvl[0] && !sB;
      quiet = (mDrv == 2'b00) && (mGap >= DT - 1);
      if (mDrv != 2'b00 || sAny) mGap = 0;
      else if (mGap < DT - 1) mGap++;
      raw = {inB, inA};
      for (int c = 0; c < 2; c++) begin
        if (raw[c] != mLvl[c]) begin
          mRun[c]++;
          if (mRun[c] == THR) begin mLvl[c] = raw[c]; mRun[c] = 0; end
        end else mRun[c] = 0;
      end
      mDrv = {wantB && (mDrv[1] || quiet), wantA && (mDrv[0] || quiet)};
    end
  end

  always @(negedge clk) begin
    logic eA, eB;
    #1;
    if (rstN && !done) begin
      eA = mDrv[0] && !(stopBoth | stopCh[0]);
      eB = mDrv[1] && !(stopBoth | stopCh[1]);
      chk(curTag, {gateBCmd, gateACmd}, {eB, eA});
      if (gateACmd) hiA++;
      if (gateBCmd) hiB++;
      if (gateACmd && !prevA) riseA = cyc;
      if (!gateACmd && prevA) fallA = cyc;
      if (gateBCmd && !prevB) riseB = cyc;
      if (!gateBCmd && prevB) fallB = cyc;
      prevA = gateACmd;
      prevB = gateBCmd;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int t0;
    logic [15:0] lfsr;
    inA = 1'b1;
    idle(5);
    #1 chk("R3", {gateBCmd, gateACmd}, 0);
    @(negedge clk);
    inA = 1'b0;
    rstN = 1'b1;
    #1 chk("R3", {gateBCmd, gateACmd}, 0);
    idle(60);

    // R1 / R2: width sweep on each channel alone
    curTag = "R2";
    for (int w = 1; w <= 40; w++) begin
      for (int ch = 0; ch < 2; ch++) begin
        @(negedge clk);
        hiA = 0; hiB = 0; t0 = cyc;
        if (ch == 0) inA = 1'b1; else inB = 1'b1;
        idle(w);
        inA = 1'b0; inB = 1'b0;
        idle(100);
        chk(w < THR ? "R1" : "R2", ch == 0 ? hiA : hiB, w < THR ? 0 : w);
        chk(w < THR ? "R1" : "R2", ch == 0 ? hiB : hiA, 0);
        if (w == 30) chk("R2", (ch == 0 ? riseA : riseB) - t0, THR + 1);
      end
    end

    // R4 then R6: A takes over from B, then hands back
    curTag = "R4";
    inB = 1'b1; idle(100);
    t0 = cyc; inA = 1'b1; idle(120);
    chk("R4", fallB - t0, THR + 1);
    chk("R4", riseA - fallB, DT);
    curTag = "R6";
    t0 = cyc; inA = 1'b0; idle(120);
    chk("R6", fallA - t0, THR + 1);
    chk("R6", riseB - fallA, DT);
    inB = 1'b0; idle(100);

    // R5: B ignored under A
    curTag = "R5";
    inA = 1'b1; idle(80);
    hiB = 0;
    inB = 1'b1; idle(30); inB = 1'b0; idle(30);
    inB = 1'b1; idle(50); inB = 1'b0; idle(30);
    chk("R5", hiB, 0);
    chk("R5", gateACmd, 1);
    inA = 1'b0; idle(100);
    chk("R5", hiB, 0);

    // R8: inputs hand over with only 5 cycles between them
    curTag = "R8";
    inA = 1'b1; idle(60);
    inA = 1'b0; idle(5);
    inB = 1'b1; idle(120);
    chk("R8", riseB - fallA, DT);
    inB = 1'b0; idle(100);

    // R9 / R11: global stop and release
    curTag = "R9";
    inA = 1'b1; idle(80);
    stopBoth = 1'b1;
    #1 chk("R9", gateACmd, 0);
    idle(20);
    chk("R9", {gateBCmd, gateACmd}, 0);
    stopBoth = 1'b0; t0 = cyc;
    idle(80);
    chk("R11", riseA - t0, DT);

    // R10: per-channel stops
    curTag = "R10";
    inB = 1'b1;
    stopCh = 2'b01;
    #1 chk("R10", gateACmd, 0);
    chk("R10", gateBCmd, 0);
    idle(20);
    stopCh = 2'b00; t0 = cyc;
    idle(80);
    chk("R11", riseA - t0, DT);
    inA = 1'b0; idle(120);
    chk("R10", gateBCmd, 1);
    stopCh = 2'b10;
    #1 chk("R10", gateBCmd, 0);
    chk("R10", gateACmd, 0);
    idle(20);
    stopCh = 2'b00; t0 = cyc;
    idle(80);
    chk("R11", riseB - t0, DT);
    inB = 1'b0; idle(100);

    // Random hold lengths on all inputs, model compared every cycle
    curTag = "R7";
    lfsr = 16'hACE1;
    for (int k = 0; k < 160; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      inA = lfsr[0];
      inB = lfsr[1] | lfsr[7];
      stopBoth = (lfsr[5:2] == 4'hF);
      stopCh = (lfsr[9:6] == 4'h0) ? lfsr[11:10] : 2'b00;
      idle(1 + int'(lfsr[15:10]));
    end
    inA = 1'b0; inB = 1'b0; stopBoth = 1'b0; stopCh = 2'b00;
    idle(100);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end
endmodule